// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the serial pins of an SPI target and its command engine and implements the pause function driven by an active-low hold pin. It samples chip select, serial clock, hold and serial input into the local clock domain. From those samples it works out whether the transfer is running or paused. While paused it freezes the engine by withholding the qualified serial clock edge strobes, holds the serial input seen by the engine at its last value, and keeps the serial output undriven. Once hold is released, the engine carries on from the bit where it stopped.

Entry into and exit from a pause take effect only while the serial clock is low. A hold change seen while the clock is high is held back until the clock next goes low. Deselecting the device in any state cancels a pause and raises the engine's transaction reset. A new selection therefore always starts from a clean transaction.

The state machine has five states:

- IDLE: the device is deselected.
- RUN: selected and transferring.
- ENTER_WAIT: hold is low while the clock is high, so the pause is pending.
- PAUSE: paused.
- EXIT_WAIT: hold is high while the clock is high, so the resume is pending.

Its transitions are:

- IDLE→RUN on selection.
- RUN→PAUSE when hold is low and the clock is low.
- RUN→ENTER_WAIT when hold is low and the clock is high.
- ENTER_WAIT→PAUSE when the clock goes low.
- ENTER_WAIT→RUN when hold is released before the clock falls.
- PAUSE→RUN when hold is high and the clock is low.
- PAUSE→EXIT_WAIT when hold is high and the clock is high.
- EXIT_WAIT→RUN when the clock goes low.
- EXIT_WAIT→PAUSE when hold drops again.
- Any state→IDLE on deselection.

Top module: `hpc_top`

## Requirements
- R1: During reset and whenever chip select is high (deselected), txn_reset_o is 1, paused_o is 0 and so_oe_o is 0.
- R2: While selected, hold_n_i low with sck_i low sets paused_o to 1 within SYNC_STAGES+3 clock cycles.
- R3: hold_n_i falling while sck_i is high leaves paused_o at 0 until sck_i goes low, and then paused_o becomes 1.
- R4: hold_n_i rising with sck_i low clears paused_o. If sck_i is high, paused_o stays 1 until sck_i goes low.
- R5: While paused_o is 1, so_oe_o is 0 and so_o is 0. While running, so_oe_o follows eng_so_en_i and so_o follows eng_so_i.
- R6: While paused_o is 1, si_o keeps the value it had when the pause began, whatever si_i does.
- R7: Serial clock edges seen while paused produce no sck_rise_o or sck_fall_o pulse. While running, each edge produces exactly one pulse of the matching kind.
- R8: Chip select going high during a pause clears paused_o and sets txn_reset_o to 1.
- R9: A hold low that is released again before sck_i falls never sets paused_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select pin, low selects |
| sck_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Hold pin, low requests a pause |
| si_i | input | 1 | Serial data input pin |
| eng_so_i | input | 1 | Output bit from the engine |
| eng_so_en_i | input | 1 | Engine wants to drive the output |
| paused_o | output | 1 | Transfer is paused |
| sck_rise_o | output | 1 | One-cycle strobe for a qualified clock rising edge |
| sck_fall_o | output | 1 | One-cycle strobe for a qualified clock falling edge |
| si_o | output | 1 | Serial input as seen by the engine |
| so_o | output | 1 | Output pin data |
| so_oe_o | output | 1 | Output pin enable, 0 means high impedance |
| txn_reset_o | output | 1 | Engine transaction reset |

## Verification
The pause is exercised from three starting conditions:

- Hold falls with the clock low, which gives an immediate pause.
- Hold falls with the clock high, which is deferred and separates R3 from R2.
- Hold is pulsed and released while the clock stays high, which must not pause (R9).

Resume is tried both with the clock low and with it high, which shows whether the release is correctly held back. Clock toggling is done while running and while paused, and the strobe counts show that edges are masked only during the pause. A deselect in the middle of a pause, followed by a reselect with hold still low, shows that the cancel and the fresh start are correct.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    localparam int PIN_CS    = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_HOLD  = 2;
    localparam int PIN_SI    = 3;
    localparam int NUM_PINS  = 4;

    // idle levels of the pins: deselected, clock low, hold released, data low
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b0101;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUN        = 3'd1,
        ST_ENTER_WAIT = 3'd2,
        ST_PAUSE      = 3'd3,
        ST_EXIT_WAIT  = 3'd4
    } hold_state_t;
endpackage

// File: rtl/hpc_pin_sampler.sv
module hpc_pin_sampler #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RESET_VAL[p]}};
                end else if (STAGES == 1) begin
                    chain[0] <= raw_i[p];
                end else begin
                    chain <= {chain[STAGES-2:0], raw_i[p]};
                end
            end
            assign lvl_o[p] = chain[LAST];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_o[p] <= RESET_VAL[p];
                else        prev_o[p] <= chain[LAST];
            end
        end
    endgenerate
endmodule

// File: rtl/hpc_hold_fsm.sv
module hpc_hold_fsm
    import hpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_s,
    input  logic        sck_s,
    input  logic        hold_s,
    output hold_state_t state_o,
    output logic        paused_o,
    output logic        selected_o
);
    hold_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_RUN;
                ST_RUN: begin
                    if (!hold_s) state_d = sck_s ? ST_ENTER_WAIT : ST_PAUSE;
                end
                ST_ENTER_WAIT: begin
                    if (hold_s)      state_d = ST_RUN;
                    else if (!sck_s) state_d = ST_PAUSE;
                end
                ST_PAUSE: begin
                    if (hold_s) state_d = sck_s ? ST_EXIT_WAIT : ST_RUN;
                end
                ST_EXIT_WAIT: begin
                    if (!hold_s)     state_d = ST_PAUSE;
                    else if (!sck_s) state_d = ST_RUN;
                end
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        paused_o   = 1'b0;
        selected_o = 1'b1;
        unique case (state_q)
            ST_IDLE:       selected_o = 1'b0;
            ST_RUN:        paused_o   = 1'b0;
            ST_ENTER_WAIT: paused_o   = 1'b0;
            ST_PAUSE:      paused_o   = 1'b1;
            ST_EXIT_WAIT:  paused_o   = 1'b1;
            default:       selected_o = 1'b0;
        endcase
    end

    AST_PAUSE_NEEDS_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused_o) |-> !$past(sck_s)); // R3
    AST_PAUSE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused_o) |-> !$past(hold_s)); // R2
    AST_RESUME_NEEDS_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused_o) |-> (!$past(sck_s) || $past(cs_s))); // R4
    AST_DESELECT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state_q == ST_IDLE)); // R8
endmodule

// File: rtl/hpc_pin_gate.sv
module hpc_pin_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic paused_i,
    input  logic selected_i,
    input  logic sck_lvl_i,
    input  logic sck_prev_i,
    input  logic si_lvl_i,
    input  logic eng_so_i,
    input  logic eng_so_en_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic si_o,
    output logic so_o,
    output logic so_oe_o,
    output logic txn_reset_o
);
    logic si_frozen_q;
    logic live;

    assign live = selected_i && !paused_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         si_frozen_q <= 1'b0;
        else if (!paused_i) si_frozen_q <= si_lvl_i;
    end

    always_comb begin
        sck_rise_o  = live && sck_lvl_i && !sck_prev_i;
        sck_fall_o  = live && !sck_lvl_i && sck_prev_i;
        si_o        = paused_i ? si_frozen_q : si_lvl_i;
        so_oe_o     = live && eng_so_en_i;
        so_o        = so_oe_o && eng_so_i;
        txn_reset_o = !selected_i;
    end

    AST_SI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_i && $past(paused_i)) |-> $stable(si_o)); // R6
    AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        paused_i |-> (!so_oe_o && !so_o)); // R5
    AST_NO_STROBE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        paused_i |-> !(sck_rise_o || sck_fall_o)); // R7
endmodule

// File: rtl/hpc_top.sv
module hpc_top
    import hpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic hold_n_i,
    input  logic si_i,
    input  logic eng_so_i,
    input  logic eng_so_en_i,
    output logic paused_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic si_o,
    output logic so_o,
    output logic so_oe_o,
    output logic txn_reset_o
);
    logic [NUM_PINS-1:0] raw, lvl, prev;
    hold_state_t         state;
    logic                selected;

    always_comb begin
        raw           = '0;
        raw[PIN_CS]   = cs_n_i;
        raw[PIN_SCK]  = sck_i;
        raw[PIN_HOLD] = hold_n_i;
        raw[PIN_SI]   = si_i;
    end

    hpc_pin_sampler #(
        .WIDTH     (NUM_PINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    hpc_hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (lvl[PIN_CS]),
        .sck_s      (lvl[PIN_SCK]),
        .hold_s     (lvl[PIN_HOLD]),
        .state_o    (state),
        .paused_o   (paused_o),
        .selected_o (selected)
    );

    hpc_pin_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .paused_i    (paused_o),
        .selected_i  (selected),
        .sck_lvl_i   (lvl[PIN_SCK]),
        .sck_prev_i  (prev[PIN_SCK]),
        .si_lvl_i    (lvl[PIN_SI]),
        .eng_so_i    (eng_so_i),
        .eng_so_en_i (eng_so_en_i),
        .sck_rise_o  (sck_rise_o),
        .sck_fall_o  (sck_fall_o),
        .si_o        (si_o),
        .so_o        (so_o),
        .so_oe_o     (so_oe_o),
        .txn_reset_o (txn_reset_o)
    );

    AST_IDLE_RESETS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (txn_reset_o && !paused_o && !so_oe_o)); // R1
endmodule

// File: tb/hpc_top_tb_top.sv
module hpc_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0, so_d = 1'b0, so_en = 1'b0;
    logic paused, rise, fall, si_out, so, so_oe, txn;
    int   checks = 0, fails = 0;
    int   rise_cnt = 0, fall_cnt = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    hpc_top dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .hold_n_i(hold_n),
        .si_i(si), .eng_so_i(so_d), .eng_so_en_i(so_en),
        .paused_o(paused), .sck_rise_o(rise), .sck_fall_o(fall), .si_o(si_out),
        .so_o(so), .so_oe_o(so_oe), .txn_reset_o(txn)
    );

    always @(posedge clk) begin
        if (rst_n && rise) rise_cnt <= rise_cnt + 1;
        if (rst_n && fall) fall_cnt <= fall_cnt + 1;
    end

    // [10]cs_n [9]sck [8]hold_n [7]si [6]so_en [5]so_d | [4]paused [3]oe [2]so [1]si_o [0]txn
    localparam logic [10:0] VEC [13] = '{
        11'b101011_00001,
        11'b001011_01100,
        11'b000011_10000,
        11'b000111_10000,
        11'b010111_10000,
        11'b011111_10000,
        11'b001110_01010,
        11'b011111_01110,
        11'b010111_01110,
        11'b000111_10010,
        11'b100111_00011,
        11'b000111_10010,
        11'b001011_01100
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R1";
            1: return "R5";
            2: return "R2";
            3: return "R6";
            4: return "R5";
            5: return "R4";
            6: return "R6";
            7: return "R5";
            8: return "R3";
            9: return "R3";
            10: return "R8";
            11: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        check("R1", "reset txn", txn, 1);
        check("R1", "reset paused", paused, 0);
        check("R1", "reset oe", so_oe, 0);
        rst_n = 1'b1;
        wait_n(3);

        for (int i = 0; i < 13; i++) begin
            logic [10:0] v;
            v = VEC[i];
            cs_n = v[10]; sck = v[9]; hold_n = v[8]; si = v[7]; so_en = v[6]; so_d = v[5];
            wait_n(6);
            check(vec_tag(i), "paused", paused, v[4]);
            check(vec_tag(i), "so_oe", so_oe, v[3]);
            check(vec_tag(i), "so", so, v[2]);
            check(vec_tag(i), "si_o", si_out, v[1]);
            check(vec_tag(i), "txn_reset", txn, v[0]);
        end

        // R7: strobes counted while running, paused and after resume
        begin
            int r0, f0;
            sck = 1'b0; hold_n = 1'b1; cs_n = 1'b0;
            wait_n(6);
            r0 = rise_cnt; f0 = fall_cnt;
            for (int k = 0; k < 3; k++) begin sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(4); end
            check("R7", "rises running", rise_cnt - r0, 3);
            check("R7", "falls running", fall_cnt - f0, 3);
            hold_n = 1'b0; wait_n(6);
            r0 = rise_cnt; f0 = fall_cnt;
            for (int k = 0; k < 3; k++) begin sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(4); end
            check("R7", "rises paused", rise_cnt - r0, 0);
            check("R7", "falls paused", fall_cnt - f0, 0);
            hold_n = 1'b1; wait_n(6);
            r0 = rise_cnt;
            for (int k = 0; k < 2; k++) begin sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(4); end
            check("R7", "rises resumed", rise_cnt - r0, 2);
        end

        // R9: hold pulse confined to a clock high phase
        sck = 1'b1; wait_n(6);
        hold_n = 1'b0; wait_n(6);
        check("R9", "pending not paused", paused, 0);
        hold_n = 1'b1; wait_n(6);
        sck = 1'b0; wait_n(6);
        check("R9", "cancelled pending", paused, 0);

        // R2: entry latency bound SYNC_STAGES+3 = 5
        hold_n = 1'b0; wait_n(5);
        check("R2", "entry latency", paused, 1);
        hold_n = 1'b1; wait_n(6);
        check("R4", "resume clock low", paused, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule